// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single reservation a processor core takes with a load-reserved access. It records the reserved word, watches two system buses at once for writes by other masters that land on that word, and tells the core when the reservation has been lost. It also gates the core's store-conditional request, so that a store-conditional whose reservation is gone never starts a bus cycle and therefore never changes memory.

The core reports each request together with the termination status of its address phase and its data phase. Only address-phase outcomes decide whether a store-conditional or a foreign write clears the reservation. A load-reserved takes effect however it terminates, including by error. A strobe from the address-map logic drops the reservation whenever the programmable memory map is rewritten.

Top module: `rsv_monitor`

## Requirements
- R1: A load-reserved request whose address phase status (`core_astat`) or data phase status (`core_dstat`) is non-zero (01 normal, 10 error, 11 retry; 00 means no termination) makes `rsv_valid` high from the next clock edge, and the error codes set it just as normal termination does.
- R2: A store-conditional with `core_astat` = 01 clears `rsv_valid` at the next edge for any `core_dstat` value. With `core_astat` 00, 10 or 11 it leaves the reservation in place.
- R3: A snoop on either bus clears the reservation at the next edge when it is a write (`snp_we`) that is address-acknowledged (`snp_aack`), that comes from a master ID other than `CORE_ID`, and that targets the reserved granule. Bus 0 uses the low slice of the packed snoop fields and bus 1 the next slice.
- R4: When a valid reservation is lost to a snoop hit, `rsv_cancel` is high for exactly the one cycle after the touch. It stays low if no reservation was valid.
- R5: `sc_go` is high only while `core_sc` is high, the reservation is valid, and no loss event occurs in the same cycle. Without a valid reservation it is low.
- R6: A store-conditional in the same cycle as a snoop hit, or in the cycle in which `rsv_cancel` is high, is aborted (`sc_go` low).
- R7: A `map_chg` pulse while a reservation is valid clears it at the next edge and raises `rsv_cancel` for one cycle.
- R8: Addresses are compared per 4-byte granule. Address bits [1:0] are ignored, and a write to a different granule has no effect.
- R9: A new load-reserved replaces the stored address. Writes to the old address no longer clear the reservation.
- R10: Snoops that are reads, that are not acknowledged, that carry `CORE_ID`, or that arrive while no reservation is valid change neither `rsv_valid` nor `rsv_cancel`.
- R11: While reset is held, and after it is released, `rsv_valid` and `rsv_cancel` are low.
- R12: A terminating load-reserved in the same cycle as a loss event wins. The reservation is valid afterwards and no cancel is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_lr | input | 1 | Core load-reserved request |
| core_sc | input | 1 | Core store-conditional request |
| core_addr | input | AW | Core request byte address |
| core_astat | input | 2 | Core address phase status: 00 none, 01 normal, 10 error, 11 retry |
| core_dstat | input | 2 | Core data phase status, same encoding |
| snp_id | input | NBUS*IDW | Master ID per snooped bus, bus 0 in the low slice |
| snp_we | input | NBUS | Write strobe per bus |
| snp_addr | input | NBUS*AW | Byte address per bus |
| snp_aack | input | NBUS | Address phase ended normally, per bus |
| map_chg | input | 1 | Memory map rewritten strobe |
| rsv_valid | output | 1 | Reservation currently held |
| rsv_cancel | output | 1 | One-cycle reservation-lost pulse |
| sc_go | output | 1 | Store-conditional may start its bus cycle |

## Verification
The assertions assume that the core never raises `core_lr` and `core_sc` in the same cycle. They also assume that snoop fields on a bus are only meaningful while `snp_we` and `snp_aack` are high. Both the directed sequences and the random phase keep to this: they pick exactly one of load-reserved, store-conditional or idle each cycle, and they draw addresses from a small pool so that granule hits, near misses within a granule and foreign granules all occur often. All inputs change only on the falling edge, so the combinational gate is settled when it is compared.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  // Termination status codes shared by the core phases.
  typedef enum logic [1:0] {
    TS_NONE  = 2'b00,
    TS_OK    = 2'b01,
    TS_ERR   = 2'b10,
    TS_RETRY = 2'b11
  } term_stat_e;

  // Any termination at all (good or bad) in either phase.
  function automatic logic phase_ended(input logic [1:0] astat, input logic [1:0] dstat);
    return (astat != TS_NONE) || (dstat != TS_NONE);
  endfunction

  // Address phase terminated normally.
  function automatic logic aphase_normal(input logic [1:0] astat);
    return astat == TS_OK;
  endfunction

  // Two byte addresses fall into the same reservation granule.
  function automatic logic same_granule(input logic [63:0] a, input logic [63:0] b,
                                        input int unsigned lsb);
    return (a >> lsb) == (b >> lsb);
  endfunction

endpackage

// File: rtl/rsv_snoop_port.sv
module rsv_snoop_port #(
  parameter int AW      = 32,
  parameter int IDW     = 3,
  parameter int GLSB    = 2,
  parameter int CORE_ID = 0
) (
  input  logic           rsv_valid,
  input  logic [AW-1:0]  rsv_addr,
  input  logic [IDW-1:0] id,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic           aack,
  output logic           hit
);
  import rsv_pkg::*;

  localparam logic [IDW-1:0] OWN_ID = IDW'(CORE_ID);

  logic foreign_write;
  logic granule_eq;

  always_comb begin
    foreign_write = we && aack && (id != OWN_ID);
    granule_eq    = same_granule(64'(addr), 64'(rsv_addr), GLSB);
    hit           = rsv_valid && foreign_write && granule_eq;
  end

endmodule

// File: rtl/rsv_track.sv
module rsv_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lr_set,
  input  logic [AW-1:0] lr_addr,
  input  logic          sc_done,
  input  logic          lost_now,
  output logic          rsv_valid,
  output logic [AW-1:0] rsv_addr,
  output logic          rsv_cancel
);

  logic          valid_d;
  logic [AW-1:0] addr_d;
  logic          cancel_d;

  always_comb begin
    valid_d  = rsv_valid;
    addr_d   = rsv_addr;
    cancel_d = 1'b0;
    if (lr_set) begin
      valid_d = 1'b1;
      addr_d  = lr_addr;
    end else begin
      if (lost_now || sc_done) valid_d = 1'b0;
      cancel_d = rsv_valid && lost_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv_valid  <= 1'b0;
      rsv_addr   <= '0;
      rsv_cancel <= 1'b0;
    end else begin
      rsv_valid  <= valid_d;
      rsv_addr   <= addr_d;
      rsv_cancel <= cancel_d;
    end
  end

  // R1 / R9: a load-reserved always leaves a valid reservation on its address
  a_r1_lr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    lr_set |=> rsv_valid);
  a_r9_addr_taken: assert property (@(posedge clk) disable iff (!rst_n)
    lr_set |=> (rsv_addr == $past(lr_addr)));
  // R2: a completed store-conditional drops the reservation
  a_r2_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && !lr_set) |=> !rsv_valid);
  // R4: the loss of a valid reservation is reported one clock later
  a_r4_cancel_next: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && lost_now && !lr_set) |=> (rsv_cancel && !rsv_valid));
  // R4: cancel is a single-cycle pulse
  a_r4_cancel_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_cancel |=> !rsv_cancel);
  // R12: a simultaneous load-reserved suppresses cancel
  a_r12_lr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lr_set |=> !rsv_cancel);

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
  parameter int AW         = 32,
  parameter int IDW        = 3,
  parameter int NBUS       = 2,
  parameter int CORE_ID    = 0,
  parameter int GRAN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                core_lr,
  input  logic                core_sc,
  input  logic [AW-1:0]       core_addr,
  input  logic [1:0]          core_astat,
  input  logic [1:0]          core_dstat,
  input  logic [NBUS*IDW-1:0] snp_id,
  input  logic [NBUS-1:0]     snp_we,
  input  logic [NBUS*AW-1:0]  snp_addr,
  input  logic [NBUS-1:0]     snp_aack,
  input  logic                map_chg,
  output logic                rsv_valid,
  output logic                rsv_cancel,
  output logic                sc_go
);
  import rsv_pkg::*;

  localparam int GLSB = $clog2(GRAN_BYTES);

  // Named internal events, shared by the logic and the assertions.
  logic            lr_set;
  logic            sc_done;
  logic [NBUS-1:0] hit_vec;
  logic            snoop_hit;
  logic            lost_now;
  logic [AW-1:0]   rsv_addr;

  always_comb begin
    lr_set    = core_lr && phase_ended(core_astat, core_dstat);
    sc_done   = core_sc && aphase_normal(core_astat);
    snoop_hit = |hit_vec;
    lost_now  = snoop_hit || (map_chg && rsv_valid);
    sc_go     = core_sc && rsv_valid && !lost_now && !rsv_cancel;
  end

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    rsv_snoop_port #(
      .AW(AW), .IDW(IDW), .GLSB(GLSB), .CORE_ID(CORE_ID)
    ) u_port (
      .rsv_valid (rsv_valid),
      .rsv_addr  (rsv_addr),
      .id        (snp_id[b*IDW +: IDW]),
      .we        (snp_we[b]),
      .addr      (snp_addr[b*AW +: AW]),
      .aack      (snp_aack[b]),
      .hit       (hit_vec[b])
    );

    // R10: the core's own ID never counts as an intrusion
    a_r10_own_id: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_id[b*IDW +: IDW] == IDW'(CORE_ID)) |-> !hit_vec[b]);
    // R3: only acknowledged writes can hit
    a_r3_needs_ack_write: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[b] |-> (snp_we[b] && snp_aack[b]));
  end

  rsv_track #(.AW(AW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .lr_set     (lr_set),
    .lr_addr    (core_addr),
    .sc_done    (sc_done),
    .lost_now   (lost_now),
    .rsv_valid  (rsv_valid),
    .rsv_addr   (rsv_addr),
    .rsv_cancel (rsv_cancel)
  );

  // R5: no store-conditional leaves without a held reservation
  a_r5_gate_needs_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    sc_go |-> (rsv_valid && core_sc));
  // R6: a cancel cycle aborts a store-conditional
  a_r6_cancel_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_cancel |-> !sc_go);
  // R7: a map rewrite ends the reservation
  a_r7_map_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (map_chg && rsv_valid && !lr_set) |=> (!rsv_valid && rsv_cancel));
  // R10: nothing is cancelled without a reservation
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsv_valid && !lr_set) |=> !rsv_cancel);

endmodule

// File: tb/sim_rsv_monitor.sv
module sim_rsv_monitor;
  localparam int CLK_P   = 10;
  localparam int AW      = 32;
  localparam int IDW     = 3;
  localparam int NBUS    = 2;
  localparam int CORE_ID = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_lr = 0, core_sc = 0, map_chg = 0;
  logic [AW-1:0] core_addr = '0;
  logic [1:0] core_astat = '0, core_dstat = '0;
  logic [NBUS*IDW-1:0] snp_id = '0;
  logic [NBUS-1:0] snp_we = '0, snp_aack = '0;
  logic [NBUS*AW-1:0] snp_addr = '0;
  logic rsv_valid, rsv_cancel, sc_go;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  bit m_valid = 0;
  bit m_cancel = 0;
  longint m_addr = 0;

  always #(CLK_P/2) clk = ~clk;

  rsv_monitor #(.AW(AW), .IDW(IDW), .NBUS(NBUS), .CORE_ID(CORE_ID)) u0 (
    .clk(clk), .rst_n(rst_n), .core_lr(core_lr), .core_sc(core_sc),
    .core_addr(core_addr), .core_astat(core_astat), .core_dstat(core_dstat),
    .snp_id(snp_id), .snp_we(snp_we), .snp_addr(snp_addr), .snp_aack(snp_aack),
    .map_chg(map_chg), .rsv_valid(rsv_valid), .rsv_cancel(rsv_cancel), .sc_go(sc_go)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, check the gate, then the registers.
  task automatic step(string tag, bit lr, bit sc, int unsigned ca, int as, int ds,
                      bit [1:0] we, int id0, int id1, int unsigned a0, int unsigned a1,
                      bit [1:0] ack, bit mc);
    bit lost;
    bit lrs;
    bit scd;
    bit exp_go;
    int unsigned ad[2];
    int ids[2];
    @(negedge clk);
    core_lr = lr; core_sc = sc; core_addr = ca;
    core_astat = 2'(as); core_dstat = 2'(ds);
    snp_we = we; snp_aack = ack; map_chg = mc;
    snp_id = {3'(id1), 3'(id0)};
    snp_addr = {a1, a0};
    ad[0] = a0; ad[1] = a1; ids[0] = id0; ids[1] = id1;
    lost = m_valid && mc;
    for (int b = 0; b < 2; b++)
      if (m_valid && we[b] && ack[b] && ids[b] != CORE_ID && (ad[b] / 4) == (m_addr / 4))
        lost = 1;
    lrs = lr && (as != 0 || ds != 0);
    scd = sc && (as == 1);
    exp_go = sc && m_valid && !lost && !m_cancel;
    #1;
    chk(tag, "sc_go", sc_go, exp_go);
    @(posedge clk);
    if (lrs) begin
      m_valid = 1; m_addr = ca; m_cancel = 0;
    end else begin
      m_cancel = m_valid && lost;
      if (lost || scd) m_valid = 0;
    end
    #1;
    chk(tag, "rsv_valid", rsv_valid, m_valid);
    chk(tag, "rsv_cancel", rsv_cancel, m_cancel);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00, 0);
  endtask
  task automatic do_lr(string tag, int unsigned a, int as, int ds);
    step(tag, 1, 0, a, as, ds, 2'b00, 0, 0, 0, 0, 2'b00, 0);
  endtask
  task automatic do_sc(string tag, int unsigned a, int as, int ds);
    step(tag, 0, 1, a, as, ds, 2'b00, 0, 0, 0, 0, 2'b00, 0);
  endtask
  task automatic snoop(string tag, int bus, int id, int unsigned a, bit we, bit ack);
    bit [1:0] w = 0;
    bit [1:0] k = 0;
    w[bus] = we; k[bus] = ack;
    if (bus == 0) step(tag, 0, 0, 0, 0, 0, w, id, 0, a, 0, k, 0);
    else          step(tag, 0, 0, 0, 0, 0, w, 0, id, 0, a, k, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "rsv_valid in reset", rsv_valid, 1'b0);
    chk("R11", "rsv_cancel in reset", rsv_cancel, 1'b0);
    @(negedge clk); rst_n = 1;
    idle("R11");

    // R1: set on normal address phase, error data phase, retry
    do_lr("R1", 32'h1000, 1, 0);
    do_lr("R1", 32'h2000, 0, 2);
    do_lr("R9", 32'h3000, 3, 0);
    // R9: old address no longer tracked
    snoop("R9", 0, 2, 32'h2000, 1, 1);
    snoop("R9", 0, 2, 32'h1000, 1, 1);
    // R8 / R3 / R4: byte-offset hit on bus 1
    snoop("R8", 1, 5, 32'h3003, 1, 1);
    idle("R4");
    // R5: no reservation
    do_sc("R5", 32'h3000, 1, 1);
    // R1: unterminated load-reserved does nothing
    do_lr("R1", 32'h4000, 0, 0);
    // R2: failed address phase keeps, normal clears despite data error
    do_lr("R2", 32'h4000, 1, 1);
    do_sc("R2", 32'h4000, 2, 0);
    do_sc("R2", 32'h4000, 3, 0);
    do_sc("R2", 32'h4000, 1, 2);
    idle("R2");
    // R10 / R8: non-intrusions
    do_lr("R10", 32'h5004, 1, 0);
    snoop("R10", 0, CORE_ID, 32'h5004, 1, 1);
    snoop("R10", 1, 3, 32'h5004, 1, 0);
    snoop("R10", 0, 3, 32'h5004, 0, 1);
    snoop("R8", 1, 3, 32'h5008, 1, 1);
    snoop("R8", 0, 3, 32'h5000, 1, 1);
    snoop("R3", 0, 3, 32'h5005, 1, 1);
    // R10: snoop with no reservation
    snoop("R10", 0, 3, 32'h5004, 1, 1);
    // R6: store-conditional with a simultaneous hit
    do_lr("R6", 32'h6000, 1, 0);
    step("R6", 0, 1, 32'h6000, 1, 0, 2'b01, 4, 0, 32'h6000, 0, 2'b01, 0);
    do_sc("R6", 32'h6000, 1, 0);
    // R6: store-conditional during the cancel cycle
    do_lr("R6", 32'h6100, 1, 0);
    snoop("R6", 1, 6, 32'h6100, 1, 1);
    do_sc("R6", 32'h6100, 1, 0);
    // R5: allowed gate
    do_lr("R5", 32'h6200, 1, 0);
    do_sc("R5", 32'h6200, 1, 0);
    // R7: map change
    do_lr("R7", 32'h7000, 1, 0);
    step("R7", 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00, 1);
    idle("R7");
    step("R7", 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00, 1);
    // R12: load-reserved alongside a hit and alongside a map change
    do_lr("R12", 32'h8000, 1, 0);
    step("R12", 1, 0, 32'h8000, 1, 0, 2'b11, 2, 3, 32'h8000, 32'h8000, 2'b11, 0);
    step("R12", 1, 0, 32'h8000, 0, 1, 2'b00, 0, 0, 0, 0, 2'b00, 1);
    // R3: both buses hit together
    step("R3", 0, 0, 0, 0, 0, 2'b11, 1, 7, 32'h8001, 32'h8002, 2'b11, 0);
    idle("R3");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned pool[4];
      int op;
      pool[0] = 32'h1000; pool[1] = 32'h1002; pool[2] = 32'h1004; pool[3] = 32'h2000;
      op = $urandom_range(0, 5);
      step("R3", op == 0, op == 1, pool[$urandom_range(0, 3)],
           $urandom_range(0, 3), $urandom_range(0, 3),
           2'($urandom_range(0, 3)), $urandom_range(0, 3), $urandom_range(0, 3),
           pool[$urandom_range(0, 3)], pool[$urandom_range(0, 3)],
           2'($urandom_range(0, 3)), $urandom_range(0, 15) == 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule